// File: doc/BRIEF.md
# Analog-Shared Port Override and Pin-Change Interrupt

This block belongs to an eight-pin port whose pins can also serve as analog converter inputs, as analog comparator inputs and as an external reference input. From a handful of control bits it computes the per-pin override signals that the pad logic uses in place of its own register settings. These cover pullup, output driver, output value and digital input enable. It also runs one shared pin-change interrupt that watches pins 7, 6 and 3.

A watched pin is masked while the analog function that shares it is active. The comparator owns pins 7 and 6 unless its disable bit is set. Pin 3 belongs to the reference input while the reference-select bit is set. An unmasked watched pin whose interrupt is enabled forces its digital input on, so it can still see edges while the device sleeps. The watched inputs are synchronized. Any change on an unmasked pin latches a sticky flag, which stays set until a clear pulse arrives. The request output is that flag gated by the global interrupt enable and the pin-change enable. The block never sees the pin direction, so a pin driven as an output still produces pin-change events.

Top module: `pinshare_ctrl`

## Requirements
- R1: Input-enable override enable of pins 7 and 6 is 1 exactly when global enable, pin-change enable and comparator-disable are all 1; their input-enable override value is always 1.
- R2: Input-enable override enable of pin 3 is 1 exactly when global enable and pin-change enable are 1 and reference-select is 0; its input-enable override value is always 1.
- R3: On pin 3 the pullup override enable and the direction override enable both equal reference-select, and both override values are 0.
- R4: Pins 5, 4, 2, 1, 0 drive every override enable and value to 0. Pins 7 and 6 drive pullup, direction and port-value overrides to 0, and pin 3 drives its port-value override to 0.
- R5: Outside sleep every pin's effective digital input enable is 1. In sleep it is 1 only on pins whose input-enable override enable is set.
- R6: A change on an unmasked watched pin sets the flag, and irq_o rises SYNC_STAGES+1 rising edges after the input changes. watch_raw_i bit 2 is pin 7, bit 1 is pin 6 and bit 0 is pin 3.
- R7: A change on a masked watched pin, or a change while the interrupt is disabled, sets nothing. A change made while masked does not fire later when the mask lifts.
- R8: The flag holds until irq_clr_i is high at a rising edge. A change detected at that same edge wins, and the flag stays set.
- R9: irq_o is the flag ANDed with global enable and pin-change enable. Dropping an enable hides the request without losing the flag.
- R10: Reset is synchronous and loads the synchronizers and previous values from the current pin inputs, so irq_o is 0 after reset even when the pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gie_i | input | 1 | Global interrupt enable |
| pc_en_i | input | 1 | Pin-change interrupt enable |
| cmp_off_i | input | 1 | Comparator disabled (unmasks pins 7, 6) |
| ref_sel_i | input | 1 | Pin 3 used as analog reference (masks pin 3) |
| sleep_i | input | 1 | Device sleeping |
| watch_raw_i | input | 3 | Raw inputs {pin7, pin6, pin3} |
| irq_clr_i | input | 1 | Flag clear pulse |
| pu_ovr_en_o | output | 8 | Pullup override enable per pin |
| pu_ovr_val_o | output | 8 | Pullup override value per pin |
| dir_ovr_en_o | output | 8 | Direction override enable per pin |
| dir_ovr_val_o | output | 8 | Direction override value per pin |
| val_ovr_en_o | output | 8 | Port value override enable per pin |
| val_ovr_val_o | output | 8 | Port value override value per pin |
| din_ovr_en_o | output | 8 | Digital input enable override enable per pin |
| din_ovr_val_o | output | 8 | Digital input enable override value per pin |
| din_en_o | output | 8 | Resulting digital input enable per pin |
| irq_o | output | 1 | Pin-change interrupt request |

## Verification
The bench releases reset with the watched pins held high. A design that reset its previous-value registers to zero would raise a spurious request there. It toggles pins while the comparator or the reference owns them, then lifts the mask. A design that kept stale edges, or that stopped tracking while masked, would fire late. It pulses clear on the same edge that a change is detected, which catches a clear that wrongly beats the event. It also drops and restores the global enable and checks that the request hides and comes back. Sleep is combined with every mask setting, which exposes an input enable that ignores the override.

// File: rtl/pinshare_pkg.sv
`timescale 1ns/1ps
package pinshare_pkg;
    localparam int PORT_W  = 8;
    localparam int WATCH_N = 3;
    localparam int PIN_HI  = 7;
    localparam int PIN_MID = 6;
    localparam int PIN_REF = 3;
    // bit positions in the watched vector
    localparam int W_HI  = 2;
    localparam int W_MID = 1;
    localparam int W_REF = 0;

    typedef struct packed {
        logic [PORT_W-1:0] pu_en;
        logic [PORT_W-1:0] pu_val;
        logic [PORT_W-1:0] dir_en;
        logic [PORT_W-1:0] dir_val;
        logic [PORT_W-1:0] val_en;
        logic [PORT_W-1:0] val_val;
        logic [PORT_W-1:0] din_en;
        logic [PORT_W-1:0] din_val;
    } ovr_t;

    typedef struct packed {
        logic [WATCH_N-1:0] prev;
        logic               flag;
    } pcd_t;
endpackage

// File: rtl/pinshare_ovr.sv
`timescale 1ns/1ps
module pinshare_ovr
    import pinshare_pkg::*;
(
    input  logic               gie,
    input  logic               pc_en,
    input  logic               cmp_off,
    input  logic               ref_sel,
    input  logic               sleep,
    output ovr_t               ovr,
    output logic [WATCH_N-1:0] active,
    output logic [PORT_W-1:0]  din_en
);
    logic pc_on;

    always_comb begin
        pc_on          = gie & pc_en;
        active         = '0;
        active[W_HI]   = pc_on & cmp_off;
        active[W_MID]  = pc_on & cmp_off;
        active[W_REF]  = pc_on & ~ref_sel;

        ovr                  = '0;
        ovr.din_en[PIN_HI]   = active[W_HI];
        ovr.din_en[PIN_MID]  = active[W_MID];
        ovr.din_en[PIN_REF]  = active[W_REF];
        ovr.din_val[PIN_HI]  = 1'b1;
        ovr.din_val[PIN_MID] = 1'b1;
        ovr.din_val[PIN_REF] = 1'b1;
        // reference use turns pullup and driver off on pin 3
        ovr.pu_en[PIN_REF]   = ref_sel;
        ovr.dir_en[PIN_REF]  = ref_sel;
    end

    for (genvar i = 0; i < PORT_W; i++) begin : g_din
        assign din_en[i] = ovr.din_en[i] ? ovr.din_val[i] : ~sleep;
    end
endmodule

// File: rtl/pinshare_sync.sv
`timescale 1ns/1ps
module pinshare_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= d;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pinshare_pcdet.sv
`timescale 1ns/1ps
module pinshare_pcdet
    import pinshare_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WATCH_N-1:0] raw,
    input  logic [WATCH_N-1:0] cur,
    input  logic [WATCH_N-1:0] active,
    input  logic               clr,
    output logic               flag
);
    pcd_t               st_d, st_q;
    logic [WATCH_N-1:0] diff;

    always_comb begin
        diff      = (cur ^ st_q.prev) & active;
        st_d      = st_q;
        st_d.prev = cur;
        if (|diff) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev <= raw;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/pinshare_ctrl.sv
`timescale 1ns/1ps
module pinshare_ctrl
    import pinshare_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gie_i,
    input  logic               pc_en_i,
    input  logic               cmp_off_i,
    input  logic               ref_sel_i,
    input  logic               sleep_i,
    input  logic [WATCH_N-1:0] watch_raw_i,
    input  logic               irq_clr_i,
    output logic [PORT_W-1:0]  pu_ovr_en_o,
    output logic [PORT_W-1:0]  pu_ovr_val_o,
    output logic [PORT_W-1:0]  dir_ovr_en_o,
    output logic [PORT_W-1:0]  dir_ovr_val_o,
    output logic [PORT_W-1:0]  val_ovr_en_o,
    output logic [PORT_W-1:0]  val_ovr_val_o,
    output logic [PORT_W-1:0]  din_ovr_en_o,
    output logic [PORT_W-1:0]  din_ovr_val_o,
    output logic [PORT_W-1:0]  din_en_o,
    output logic               irq_o
);
    ovr_t               ovr;
    logic [WATCH_N-1:0] active;
    logic [WATCH_N-1:0] synced;
    logic               flag;

    pinshare_ovr u_ovr (
        .gie     (gie_i),
        .pc_en   (pc_en_i),
        .cmp_off (cmp_off_i),
        .ref_sel (ref_sel_i),
        .sleep   (sleep_i),
        .ovr     (ovr),
        .active  (active),
        .din_en  (din_en_o)
    );

    pinshare_sync #(.W(WATCH_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (watch_raw_i),
        .q     (synced)
    );

    pinshare_pcdet u_pcdet (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (watch_raw_i),
        .cur    (synced),
        .active (active),
        .clr    (irq_clr_i),
        .flag   (flag)
    );

    assign pu_ovr_en_o   = ovr.pu_en;
    assign pu_ovr_val_o  = ovr.pu_val;
    assign dir_ovr_en_o  = ovr.dir_en;
    assign dir_ovr_val_o = ovr.dir_val;
    assign val_ovr_en_o  = ovr.val_en;
    assign val_ovr_val_o = ovr.val_val;
    assign din_ovr_en_o  = ovr.din_en;
    assign din_ovr_val_o = ovr.din_val;
    assign irq_o         = flag & gie_i & pc_en_i;
endmodule

// File: rtl/pinshare_ctrl_chk.sv
`timescale 1ns/1ps
module pinshare_ctrl_chk
    import pinshare_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               gie_i,
    input logic               pc_en_i,
    input logic               cmp_off_i,
    input logic               ref_sel_i,
    input logic               sleep_i,
    input logic [WATCH_N-1:0] watch_raw_i,
    input logic               irq_clr_i,
    input logic [PORT_W-1:0]  pu_ovr_en_o,
    input logic [PORT_W-1:0]  pu_ovr_val_o,
    input logic [PORT_W-1:0]  dir_ovr_en_o,
    input logic [PORT_W-1:0]  dir_ovr_val_o,
    input logic [PORT_W-1:0]  val_ovr_en_o,
    input logic [PORT_W-1:0]  val_ovr_val_o,
    input logic [PORT_W-1:0]  din_ovr_en_o,
    input logic [PORT_W-1:0]  din_ovr_val_o,
    input logic [PORT_W-1:0]  din_en_o,
    input logic               irq_o
);
    localparam logic [PORT_W-1:0] QUIET = 8'b0011_0111;

    // R1
    hi_din_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (din_ovr_en_o[PIN_HI] == (gie_i && pc_en_i && cmp_off_i)) && din_ovr_val_o[PIN_MID]);
    // R2
    ref_din_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (din_ovr_en_o[PIN_REF] == (gie_i && pc_en_i && !ref_sel_i)) && din_ovr_val_o[PIN_REF]);
    // R3
    ref_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_sel_i |-> (pu_ovr_en_o[PIN_REF] && dir_ovr_en_o[PIN_REF]
                       && !pu_ovr_val_o[PIN_REF] && !dir_ovr_val_o[PIN_REF]));
    // R4
    quiet_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pu_ovr_en_o | pu_ovr_val_o | dir_ovr_en_o | dir_ovr_val_o
          | val_ovr_en_o | val_ovr_val_o | din_ovr_en_o | din_ovr_val_o) & QUIET) == '0);
    // R5
    awake_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |-> (&din_en_o));
    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> (irq_o || !(gie_i && pc_en_i)));
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gie_i && pc_en_i));
    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !irq_o);

    logic unused_ok;
    assign unused_ok = ^{watch_raw_i};
endmodule

bind pinshare_ctrl pinshare_ctrl_chk u_chk (.*);

// File: tb/pinshare_ctrl_bench.sv
`timescale 1ns/1ps
module pinshare_ctrl_bench;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gie = 1'b0, pce = 1'b0, cmpoff = 1'b0, refsel = 1'b0, slp = 1'b0, clr = 1'b0;
    logic [2:0] raw = 3'b111;
    logic [7:0] pu_en, pu_val, dir_en, dir_val, val_en, val_val, dine, dinv, din_en;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pinshare_ctrl #(.SYNC_STAGES(SYNC)) u_pinshare_ctrl (
        .clk(clk), .rst_n(rst_n), .gie_i(gie), .pc_en_i(pce), .cmp_off_i(cmpoff),
        .ref_sel_i(refsel), .sleep_i(slp), .watch_raw_i(raw), .irq_clr_i(clr),
        .pu_ovr_en_o(pu_en), .pu_ovr_val_o(pu_val), .dir_ovr_en_o(dir_en),
        .dir_ovr_val_o(dir_val), .val_ovr_en_o(val_en), .val_ovr_val_o(val_val),
        .din_ovr_en_o(dine), .din_ovr_val_o(dinv), .din_en_o(din_en), .irq_o(irq)
    );

    // behavioural reference
    logic [2:0] mq[$];
    logic [2:0] mprev, mact, mchg, mold;
    logic       mflag = 1'b0;

    function automatic logic [2:0] want_active();
        logic [2:0] a;
        a[2] = gie && pce && cmpoff;
        a[1] = gie && pce && cmpoff;
        a[0] = gie && pce && !refsel;
        return a;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            for (int i = 0; i < SYNC; i++) mq.push_back(raw);
            mprev = raw;
            mflag = 1'b0;
        end else begin
            mact = want_active();
            mold = mq[SYNC-1];
            mchg = (mold ^ mprev) & mact;
            if (mchg != 3'b000) mflag = 1'b1;
            else if (clr) mflag = 1'b0;
            mprev = mold;
            mq.push_front(raw);
            void'(mq.pop_back());
        end
    end

    task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [2:0] a;
        logic [7:0] e_dine, e_din;
        a = want_active();
        e_dine = {a[2], a[1], 2'b00, a[0], 3'b000};
        chk(dine[7:6] == a[2:1] && dinv[7:6] == 2'b11, "R1 pin7/6 input override", {dine[7:6], dinv[7:6], 4'b0}, {a[2:1], 2'b11, 4'b0});
        chk(dine[3] == a[0] && dinv[3], "R2 pin3 input override", {6'b0, dine[3], dinv[3]}, {6'b0, a[0], 1'b1});
        chk(pu_en[3] == refsel && dir_en[3] == refsel && !pu_val[3] && !dir_val[3],
            "R3 pin3 pullup/driver", {4'b0, pu_en[3], dir_en[3], pu_val[3], dir_val[3]}, {4'b0, refsel, refsel, 2'b00});
        chk(((pu_en & 8'b0011_0111) | pu_val | (dir_en & 8'b0011_0111) | dir_val | val_en | val_val
             | (dine & 8'b0011_0111) | (dinv & 8'b0011_0111)) == 8'h00,
            "R4 quiet overrides", pu_val | dir_val | val_en | val_val, 8'h00);
        for (int i = 0; i < 8; i++) e_din[i] = e_dine[i] ? 1'b1 : !slp;
        chk(din_en == e_din, "R5 input enable", din_en, e_din);
        chk(irq == (mflag && gie && pce), "R6 irq vs model", {7'b0, irq}, {7'b0, mflag && gie && pce});
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            if (rst_n) compare_all();
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        // R10: reset with pins held high, enables on
        raw = 3'b111; gie = 1; pce = 1; cmpoff = 1; refsel = 0;
        tick(3);
        rst_n = 1;
        tick(SYNC + 3);
        chk(irq == 1'b0, "R10 no irq after reset", {7'b0, irq}, 8'h00);

        // R6: change on pin 7
        raw = 3'b011;
        tick(SYNC);
        chk(irq == 1'b0, "R6 not yet", {7'b0, irq}, 8'h00);
        tick(1);
        chk(irq == 1'b1, "R6 irq after sync", {7'b0, irq}, 8'h01);
        tick(4);
        chk(irq == 1'b1, "R8 flag holds", {7'b0, irq}, 8'h01);
        clr = 1; tick(1); clr = 0;
        chk(irq == 1'b0, "R8 clear", {7'b0, irq}, 8'h00);

        // R7: comparator owns pins 7/6
        cmpoff = 0;
        raw = 3'b001;
        tick(SYNC + 3);
        chk(irq == 1'b0, "R7 masked pin6", {7'b0, irq}, 8'h00);
        cmpoff = 1;
        tick(SYNC + 3);
        chk(irq == 1'b0, "R7 no stale fire", {7'b0, irq}, 8'h00);

        // R7 / R3: reference owns pin 3, also in sleep (R5)
        refsel = 1; slp = 1;
        raw = 3'b000;
        tick(SYNC + 3);
        chk(irq == 1'b0, "R7 masked pin3", {7'b0, irq}, 8'h00);
        chk(din_en == 8'b1100_0000, "R5 sleep pin3 masked", din_en, 8'b1100_0000);
        refsel = 0;
        tick(1);
        chk(din_en == 8'b1100_1000, "R5 sleep unmasked", din_en, 8'b1100_1000);

        // R7: disabled interrupt ignores change
        gie = 0;
        raw = 3'b001;
        tick(SYNC + 3);
        chk(irq == 1'b0 && din_en == 8'h00, "R7 disabled", {irq, din_en[6:0]}, 8'h00);
        gie = 1;
        tick(SYNC + 2);
        chk(irq == 1'b0, "R7 disabled no stale", {7'b0, irq}, 8'h00);
        slp = 0;

        // R6 on pin 3
        raw = 3'b000;
        tick(SYNC + 1);
        chk(irq == 1'b1, "R6 pin3 change", {7'b0, irq}, 8'h01);

        // R9 gating
        gie = 0;
        tick(1);
        chk(irq == 1'b0, "R9 hidden", {7'b0, irq}, 8'h00);
        pce = 0; gie = 1;
        tick(1);
        chk(irq == 1'b0, "R9 hidden by pc enable", {7'b0, irq}, 8'h00);
        pce = 1;
        tick(1);
        chk(irq == 1'b1, "R9 restored", {7'b0, irq}, 8'h01);

        // R8: change and clear at same edge
        raw = 3'b100;
        tick(SYNC);
        clr = 1;
        tick(1);
        clr = 0;
        chk(irq == 1'b1, "R8 change beats clear", {7'b0, irq}, 8'h01);
        clr = 1; tick(1); clr = 0;
        chk(irq == 1'b0, "R8 clear after", {7'b0, irq}, 8'h00);

        // rapid toggles and mixed patterns against the model
        for (int j = 0; j < 40; j++) begin
            raw = 3'(j * 5 + 1);
            cmpoff = j[2];
            refsel = j[3];
            slp = j[1];
            clr = (j % 7) == 0;
            tick(1);
        end
        clr = 0;
        tick(SYNC + 2);
        report();
    end
endmodule